// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Unit

This block holds the single reservation that links a load-reserved access to a later store-conditional. A load-reserved request records the aligned block that holds its address. A store-conditional request then checks that record. When the record is valid and covers the same block, the unit raises the memory write enable and reports success on the condition flag. Otherwise it blocks the write and reports failure. Any store-conditional clears the record, whatever its outcome. A write seen on the snoop port from another agent clears the record when it hits the reserved block.

The block size is a parameter, 32 bytes by default. Address bits below the block size are not used in the compare. A correct program issues both halves of a pair with the same address. The unit registers its results, so the write enable and the flag appear one cycle after the request. The memory array and the condition register are outside this unit.

Top module: `lsc_reservation`

## Requirements
- R1: After reset no reservation is held, and `mem_we`, `flag_valid` and `flag_ok` are 0. A store-conditional issued first after reset fails.
- R2: A load-reserved request (`req_op`=0) makes a reservation. A following store-conditional (`req_op`=1) to the same block gives `mem_we`=1, `flag_valid`=1 and `flag_ok`=1 in the cycle after the request.
- R3: The address compare uses only bits [ADDR_W-1:5], so any two byte addresses inside the same 32-byte aligned block match.
- R4: A store-conditional without a valid reservation gives `mem_we`=0, `flag_valid`=1 and `flag_ok`=0 in the cycle after the request.
- R5: A store-conditional to a block other than the reserved one fails (`mem_we`=0, `flag_ok`=0), even when a reservation is valid.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails. A second store-conditional after it fails.
- R7: A snoop write (`snoop_valid`=1) to any byte of the reserved block clears the reservation. A snoop write to another block leaves it in place.
- R8: A new load-reserved replaces the earlier reservation address.
- R9: A snoop write to the reserved block in the same cycle as a store-conditional makes that store-conditional fail. A load-reserved in the same cycle as a snoop write keeps its new reservation.
- R10: `mem_we` and `flag_valid` are high only in the cycle after a store-conditional request. A load-reserved request, or a cycle with no request, leaves both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = load-reserved, 1 = store-conditional |
| req_addr | input | ADDR_W | Request byte address |
| snoop_valid | input | 1 | Write by another agent seen this cycle |
| snoop_addr | input | ADDR_W | Byte address of the snooped write |
| mem_we | output | 1 | Write enable to memory for the store-conditional |
| flag_valid | output | 1 | Condition flag update strobe |
| flag_ok | output | 1 | Condition flag value: 1 = success, 0 = failure |

## Verification
The hardest case to reach from the ports is a snoop that hits the reserved block in the same cycle as a store-conditional. Directed stimulus first makes a reservation. It then drives both ports in one cycle with addresses that differ only in their low bits. Random traffic runs over a space of only a few blocks, so that snoop hits, stale reservations and same-cycle collisions happen often. A cycle-accurate model checks every result.

// File: rtl/lsc_resv_pkg.sv
package lsc_resv_pkg;
  localparam logic OP_LOAD_RSV  = 1'b0;
  localparam logic OP_STORE_CND = 1'b1;

  typedef struct packed {
    logic we;
    logic fvalid;
    logic fok;
  } resv_result_t;
endpackage

// File: rtl/lsc_blk_cmp.sv
module lsc_blk_cmp #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5,
  localparam int TAG_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tag,
  output logic [TAG_W-1:0]  addr_tag,
  output logic              hit
);
  always_comb begin
    addr_tag = addr[ADDR_W-1:OFS_W];
    hit      = (addr_tag == tag);
  end
endmodule

// File: rtl/lsc_resv_track.sv
module lsc_resv_track #(
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  output logic             resv_valid,
  output logic [TAG_W-1:0] resv_tag
);
  logic             valid_nxt;
  logic [TAG_W-1:0] tag_nxt;
  logic             tag_en;

  always_comb begin
    valid_nxt = resv_valid;
    tag_en    = 1'b0;
    tag_nxt   = set_tag;
    if (set_en) begin
      valid_nxt = 1'b1;
      tag_en    = 1'b1;
    end else if (clr_en) begin
      valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resv_valid <= 1'b0;
    else        resv_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      resv_tag <= '0;
    else if (tag_en) resv_tag <= tag_nxt;
  end
endmodule

// File: rtl/lsc_reservation.sv
module lsc_reservation
  import lsc_resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              mem_we,
  output logic              flag_valid,
  output logic              flag_ok
);
  localparam int OFS_W = $clog2(BLOCK_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic             resv_valid;
  logic [TAG_W-1:0] resv_tag;
  logic [TAG_W-1:0] req_tag;
  logic [TAG_W-1:0] snp_tag;
  logic             req_hit;
  logic             snp_hit;
  logic             is_lr;
  logic             is_sc;
  logic             snoop_kill;
  logic             clr_en;
  resv_result_t     res_nxt;
  resv_result_t     res_q;

  lsc_blk_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_req_cmp (
    .addr(req_addr), .tag(resv_tag), .addr_tag(req_tag), .hit(req_hit)
  );

  lsc_blk_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_snp_cmp (
    .addr(snoop_addr), .tag(resv_tag), .addr_tag(snp_tag), .hit(snp_hit)
  );

  always_comb begin
    is_lr      = req_valid && (req_op == OP_LOAD_RSV);
    is_sc      = req_valid && (req_op == OP_STORE_CND);
    snoop_kill = snoop_valid && snp_hit;
    clr_en     = is_sc || snoop_kill;
    res_nxt.we     = is_sc && resv_valid && req_hit && !snoop_kill;
    res_nxt.fvalid = is_sc;
    res_nxt.fok    = res_nxt.we;
  end

  lsc_resv_track #(.TAG_W(TAG_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .set_en(is_lr), .set_tag(req_tag), .clr_en(clr_en),
    .resv_valid(resv_valid), .resv_tag(resv_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_nxt;
  end

  assign mem_we     = res_q.we;
  assign flag_valid = res_q.fvalid;
  assign flag_ok    = res_q.fok;
endmodule

// File: rtl/lsc_reservation_chk.sv
module lsc_reservation_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_op,
  input logic snoop_valid,
  input logic snp_hit,
  input logic req_hit,
  input logic resv_valid,
  input logic mem_we,
  input logic flag_valid,
  input logic flag_ok
);
  // R4
  write_needs_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (flag_valid && flag_ok));

  // R10
  strobe_after_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid |-> $past(req_valid && req_op));

  // R6
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op) |=> !resv_valid);

  // R7
  snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snp_hit && !(req_valid && !req_op)) |=> !resv_valid);

  // R2
  sc_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op && resv_valid && req_hit && !(snoop_valid && snp_hit)) |=> mem_we);

  // R8
  lr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_op) |=> resv_valid);
endmodule

bind lsc_reservation lsc_reservation_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .snoop_valid(snoop_valid), .snp_hit(snp_hit), .req_hit(req_hit),
  .resv_valid(resv_valid), .mem_we(mem_we), .flag_valid(flag_valid),
  .flag_ok(flag_ok)
);

// File: tb/lsc_reservation_test.sv
module lsc_reservation_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_op, snoop_valid;
  logic [AW-1:0] req_addr, snoop_addr;
  logic          mem_we, flag_valid, flag_ok;

  int  vectors = 0;
  int  errors  = 0;
  bit  done    = 0;

  bit          m_valid;
  int unsigned m_blk;
  bit          e_we, e_fv, e_fok;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsc_reservation uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_we(mem_we), .flag_valid(flag_valid), .flag_ok(flag_ok)
  );

  function automatic int unsigned blk(input logic [AW-1:0] a);
    return int'(a >> 5);
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (mem_we !== e_we || flag_valid !== e_fv || flag_ok !== e_fok) begin
      errors++;
      $display("FAIL %s: we/fv/ok actual=%b%b%b expected=%b%b%b",
               tag, mem_we, flag_valid, flag_ok, e_we, e_fv, e_fok);
    end
  endtask

  task automatic step(input string tag, input bit v, input bit op,
                      input logic [AW-1:0] a, input bit sv,
                      input logic [AW-1:0] sa);
    bit kill;
    req_valid = v; req_op = op; req_addr = a;
    snoop_valid = sv; snoop_addr = sa;
    @(posedge clk);
    kill  = sv && m_valid && (blk(sa) == m_blk);
    e_fv  = v && op;
    e_we  = v && op && m_valid && (blk(a) == m_blk) && !kill;
    e_fok = e_we;
    if (v && !op) begin m_valid = 1; m_blk = blk(a); end
    else if ((v && op) || kill) m_valid = 0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = '0;
    snoop_valid = 0; snoop_addr = '0;
    m_valid = 0; m_blk = 0; e_we = 0; e_fv = 0; e_fok = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    step("R1 sc after reset", 1, 1, 32'h100, 0, 0);
    step("R10 idle", 0, 0, 0, 0, 0);
    step("R10 lr no strobe", 1, 0, 32'h100, 0, 0);
    step("R2 sc success", 1, 1, 32'h100, 0, 0);
    step("R6 second sc fails", 1, 1, 32'h100, 0, 0);
    step("R3 lr", 1, 0, 32'h203, 0, 0);
    step("R3 sc other byte same block", 1, 1, 32'h21F, 0, 0);
    step("R5 lr", 1, 0, 32'h300, 0, 0);
    step("R5 sc other block", 1, 1, 32'h320, 0, 0);
    step("R6 fail also clears", 1, 1, 32'h300, 0, 0);
    step("R7 lr", 1, 0, 32'h400, 0, 0);
    step("R7 snoop other block", 0, 0, 0, 1, 32'h420);
    step("R7 sc survives", 1, 1, 32'h400, 0, 0);
    step("R7 lr", 1, 0, 32'h400, 0, 0);
    step("R7 snoop hit", 0, 0, 0, 1, 32'h41C);
    step("R7 sc after snoop", 1, 1, 32'h400, 0, 0);
    step("R8 lr a", 1, 0, 32'h500, 0, 0);
    step("R8 lr b", 1, 0, 32'h600, 0, 0);
    step("R8 sc old", 1, 1, 32'h500, 0, 0);
    step("R8 lr b", 1, 0, 32'h600, 0, 0);
    step("R8 sc new", 1, 1, 32'h600, 0, 0);
    step("R9 lr", 1, 0, 32'h700, 0, 0);
    step("R9 sc with same-cycle snoop", 1, 1, 32'h700, 1, 32'h711);
    step("R9 lr with snoop", 1, 0, 32'h800, 1, 32'h800);
    step("R9 sc after", 1, 1, 32'h800, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      step("R2 random", $urandom_range(0, 1), $urandom_range(0, 1),
           AW'($urandom_range(0, 127)), $urandom_range(0, 3) == 0,
           AW'($urandom_range(0, 127)));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule